// File: doc/BRIEF.md
# Masked Keypad Interrupt Controller

This block keeps a word of up to sixteen key-down flags and produces an active-low interrupt when a key that the mask does not hide goes down. Key activity arrives as single-cycle events. Each event carries a key index and a flag that says whether the key went down or came up. Once the interrupt is raised it stays raised until one of three release rules fires. The first rule fires when no unmasked key is still held, and only if mode bit 0 is clear. The second fires when the key word is read, and only if mode bit 1 is set. The third fires when the keypad control register is written with its scan bit set.

A two-state machine holds the interrupt. In state `KP_QUIET` the line is high. In state `KP_ASSERTED` the line is low. The transition *raise* goes from `KP_QUIET` to `KP_ASSERTED` on a key-down event that leaves an unmasked key held. The transition *release* goes from `KP_ASSERTED` to `KP_QUIET` when any release rule fires. In every other case the state holds.

When a key event and a register access fall in the same cycle, the key event is applied first and the release rules are evaluated on the result. A release rule firing in the same cycle therefore stops the *raise* transition.

The control register also stores a 3-bit debounce value. It reads back with the interrupt status and a combined scan/idle flag. The mode register reads back mode bit 0.

Top module: `keypad_irq_ctrl`

## Requirements
- R1: After reset the following hold:
  - `key_state` is 0, `irq_n` is 1 and `irq_status` is 0.
  - `ctl_rdata` reads 0x4000, because scan is 1 and debounce is 0.
  - `cfg_rdata` reads 0x4000, because mode is 3.
  - The mask is 0.
- R2: A key-down event for key n sets bit n of `key_state` on the next clock. A key-up event clears that bit.
- R3: In state `KP_QUIET`, a key-down event that leaves at least one held key whose mask bit is 0 drives `irq_n` low and `irq_status` high on the next clock.
- R4: A key-down event that leaves only masked keys held does not raise the interrupt. A mask bit of 1 hides its key.
- R5: When a key event leaves no unmasked key held and mode bit 0 is clear, an active interrupt is released. When mode bit 0 is set, the interrupt stays active.
- R6: A pulse on `data_rd` releases an active interrupt when mode bit 1 is set. The pulse has no effect when mode bit 1 is clear.
- R7: A write of `ctl_wdata` stores bits 13:11 as the debounce value and bit 14 as the scan bit. If bit 14 is 1, an active interrupt is released. If bit 14 is 0, the interrupt state is unchanged.
- R8: `ctl_rdata` is laid out as follows:
  - bit 15 is the interrupt status;
  - bit 14 is (scan bit OR no key held);
  - bits 13:11 are the debounce value;
  - all other bits read 0.
- R9: A write of `cfg_wdata` loads the mode from bits 15:14. `cfg_rdata` returns mode bit 0 in bit 14, and all other bits read 0.
- R10: A key-down event that coincides with a releasing access is applied to `key_state`, but the interrupt stays released. The releasing access is a scan write, or a `data_rd` pulse when mode bit 1 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_vld | input | 1 | One-cycle key event strobe |
| key_idx | input | 4 | Index of the key in the event |
| key_press | input | 1 | 1 = key went down, 0 = key came up |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | 16 | New mask; 1 hides a key |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_wdata | input | 16 | Mode write data; mode taken from bits 15:14 |
| ctl_we | input | 1 | Keypad control register write strobe |
| ctl_wdata | input | 16 | Control write data; scan bit 14, debounce bits 13:11 |
| data_rd | input | 1 | One-cycle strobe marking a read of the key word |
| key_state | output | 16 | Key-down flags |
| ctl_rdata | output | 16 | Control register readback |
| cfg_rdata | output | 16 | Mode register readback |
| irq_status | output | 1 | Interrupt active |
| irq_n | output | 1 | Interrupt line, active low |

## Verification
The bench builds the block with its default of sixteen keys. This makes the whole mask word reachable, so keys on both sides of a mask boundary can be exercised. Mode is set in turn to 3, 0, 1 and 2, which gives every combination of the two release-rule bits. With these settings the bench drives key-down events that coincide with a scan write and with a key-word read, and it checks that the key bit is set while the interrupt stays released.

// File: rtl/kp_pkg.sv
package kp_pkg;
    localparam int REG_W        = 16;
    localparam int DBNC_W       = 3;
    localparam int DBNC_LSB     = 11;
    localparam int SCAN_BIT     = 14;
    localparam int STAT_BIT     = 15;
    localparam int MODE_LSB     = 14;
    localparam int MODE_W       = 2;
    localparam logic [MODE_W-1:0] MODE_RST = 2'b11;

    typedef enum logic {
        KP_QUIET    = 1'b0,
        KP_ASSERTED = 1'b1
    } kp_state_e;
endpackage

// File: rtl/kp_key_tracker.sv
module kp_key_tracker #(
    parameter int NUM_KEYS = 16,
    localparam int IDX_W = $clog2(NUM_KEYS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ev_vld,
    input  logic [IDX_W-1:0]    ev_idx,
    input  logic                ev_press,
    output logic [NUM_KEYS-1:0] keys_q,
    output logic [NUM_KEYS-1:0] keys_next
);
    always_comb begin
        keys_next = keys_q;
        if (ev_vld && (int'(ev_idx) < NUM_KEYS))
            keys_next[ev_idx] = ev_press;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) keys_q <= '0;
        else        keys_q <= keys_next;
    end
endmodule

// File: rtl/kp_cfg_regs.sv
module kp_cfg_regs
    import kp_pkg::*;
#(
    parameter int NUM_KEYS = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mask_we,
    input  logic [NUM_KEYS-1:0]  mask_wdata,
    input  logic                 cfg_we,
    input  logic [REG_W-1:0]     cfg_wdata,
    input  logic                 ctl_we,
    input  logic [REG_W-1:0]     ctl_wdata,
    output logic [NUM_KEYS-1:0]  mask_next,
    output logic [MODE_W-1:0]    mode_q,
    output logic                 scan_q,
    output logic [DBNC_W-1:0]    dbnc_q
);
    logic [NUM_KEYS-1:0] mask_q;

    assign mask_next = mask_we ? mask_wdata : mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            mode_q <= MODE_RST;
            scan_q <= 1'b1;
            dbnc_q <= '0;
        end else begin
            mask_q <= mask_next;
            if (cfg_we) mode_q <= cfg_wdata[MODE_LSB +: MODE_W];
            if (ctl_we) begin
                scan_q <= ctl_wdata[SCAN_BIT];
                dbnc_q <= ctl_wdata[DBNC_LSB +: DBNC_W];
            end
        end
    end
endmodule

// File: rtl/kp_irq_fsm.sv
module kp_irq_fsm
    import kp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_ev,
    input  logic              press_ev,
    input  logic              hit_next,
    input  logic [MODE_W-1:0] mode_q,
    input  logic              scan_clr,
    input  logic              data_rd,
    output logic              irq_active
);
    kp_state_e cur_st, nxt_st;
    logic      release_now;

    // Releasing rules are evaluated on the key word after this cycle's event.
    always_comb begin
        release_now = scan_clr
                    | (data_rd & mode_q[1])
                    | (key_ev & ~hit_next & ~mode_q[0]);
        nxt_st = cur_st;
        unique case (cur_st)
            KP_QUIET:    if (press_ev && hit_next && !release_now) nxt_st = KP_ASSERTED;
            KP_ASSERTED: if (release_now) nxt_st = KP_QUIET;
            default:     nxt_st = KP_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_st <= KP_QUIET;
        else        cur_st <= nxt_st;
    end

    always_comb begin
        irq_active = (cur_st == KP_ASSERTED);
    end
endmodule

// File: rtl/keypad_irq_ctrl.sv
module keypad_irq_ctrl
    import kp_pkg::*;
#(
    parameter int NUM_KEYS = 16,
    localparam int IDX_W = $clog2(NUM_KEYS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                key_vld,
    input  logic [IDX_W-1:0]    key_idx,
    input  logic                key_press,
    input  logic                mask_we,
    input  logic [NUM_KEYS-1:0] mask_wdata,
    input  logic                cfg_we,
    input  logic [REG_W-1:0]    cfg_wdata,
    input  logic                ctl_we,
    input  logic [REG_W-1:0]    ctl_wdata,
    input  logic                data_rd,
    output logic [NUM_KEYS-1:0] key_state,
    output logic [REG_W-1:0]    ctl_rdata,
    output logic [REG_W-1:0]    cfg_rdata,
    output logic                irq_status,
    output logic                irq_n
);
    logic [NUM_KEYS-1:0] keys_next;
    logic [NUM_KEYS-1:0] mask_next;
    logic [MODE_W-1:0]   mode_q;
    logic                scan_q;
    logic [DBNC_W-1:0]   dbnc_q;
    logic                irq_active;
    logic                hit_next;

    kp_key_tracker #(.NUM_KEYS(NUM_KEYS)) u_keys (
        .clk(clk), .rst_n(rst_n),
        .ev_vld(key_vld), .ev_idx(key_idx), .ev_press(key_press),
        .keys_q(key_state), .keys_next(keys_next)
    );

    kp_cfg_regs #(.NUM_KEYS(NUM_KEYS)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .mask_we(mask_we), .mask_wdata(mask_wdata),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .mask_next(mask_next), .mode_q(mode_q),
        .scan_q(scan_q), .dbnc_q(dbnc_q)
    );

    assign hit_next = |(keys_next & ~mask_next);

    kp_irq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .key_ev(key_vld), .press_ev(key_vld & key_press),
        .hit_next(hit_next), .mode_q(mode_q),
        .scan_clr(ctl_we & ctl_wdata[SCAN_BIT]),
        .data_rd(data_rd), .irq_active(irq_active)
    );

    assign irq_status = irq_active;
    assign irq_n      = ~irq_active;

    always_comb begin
        ctl_rdata = '0;
        ctl_rdata[STAT_BIT] = irq_active;
        ctl_rdata[SCAN_BIT] = scan_q | ~(|key_state);
        ctl_rdata[DBNC_LSB +: DBNC_W] = dbnc_q;
        cfg_rdata = '0;
        cfg_rdata[MODE_LSB] = mode_q[0];
    end
endmodule

// File: rtl/kp_irq_chk.sv
module kp_irq_chk
    import kp_pkg::*;
#(
    parameter int NUM_KEYS = 16,
    localparam int IDX_W = $clog2(NUM_KEYS)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                key_vld,
    input logic [IDX_W-1:0]    key_idx,
    input logic                key_press,
    input logic                ctl_we,
    input logic [REG_W-1:0]    ctl_wdata,
    input logic                data_rd,
    input logic [MODE_W-1:0]   mode_q,
    input logic [NUM_KEYS-1:0] key_state,
    input logic                irq_status,
    input logic                irq_n
);
    // R2
    key_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (key_vld && key_press) |=> key_state[$past(key_idx)]);

    // R3
    raise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> $past(key_vld && key_press));

    // R7
    scan_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && ctl_wdata[SCAN_BIT]) |=> !irq_status);

    // R6
    read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && mode_q[1]) |=> !irq_status);

    // R4
    no_press_no_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(key_vld && key_press)) |=> !$rose(irq_status));
endmodule

bind keypad_irq_ctrl kp_irq_chk #(.NUM_KEYS(NUM_KEYS)) u_chk (
    .clk(clk), .rst_n(rst_n), .key_vld(key_vld), .key_idx(key_idx),
    .key_press(key_press), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .data_rd(data_rd), .mode_q(mode_q), .key_state(key_state),
    .irq_status(irq_status), .irq_n(irq_n)
);

// File: tb/keypad_irq_ctrl_tb.sv
module keypad_irq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        key_vld = 1'b0;
    logic [3:0]  key_idx = '0;
    logic        key_press = 1'b0;
    logic        mask_we = 1'b0;
    logic [15:0] mask_wdata = '0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        ctl_we = 1'b0;
    logic [15:0] ctl_wdata = '0;
    logic        data_rd = 1'b0;
    logic [15:0] key_state, ctl_rdata, cfg_rdata;
    logic        irq_status, irq_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    keypad_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .key_vld(key_vld), .key_idx(key_idx),
        .key_press(key_press), .mask_we(mask_we), .mask_wdata(mask_wdata),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .ctl_we(ctl_we),
        .ctl_wdata(ctl_wdata), .data_rd(data_rd), .key_state(key_state),
        .ctl_rdata(ctl_rdata), .cfg_rdata(cfg_rdata),
        .irq_status(irq_status), .irq_n(irq_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        key_vld = 0; mask_we = 0; cfg_we = 0; ctl_we = 0; data_rd = 0;
    endtask

    task automatic key_ev(input int idx, input bit down);
        key_vld = 1; key_idx = idx[3:0]; key_press = down;
    endtask

    task automatic chk_irq(input string tag, input bit active);
        chk(tag, {irq_status, irq_n}, {active, ~active});
    endtask

    task automatic t_reset();
        chk("R1 key_state", key_state, 0);
        chk_irq("R1 irq", 0);
        chk("R1 ctl_rdata", ctl_rdata, 16'h4000);
        chk("R1 cfg_rdata", cfg_rdata, 16'h4000);
    endtask

    task automatic t_default_mode();
        key_ev(3, 1); tick();
        chk("R2 key set", key_state, 16'h0008);
        chk_irq("R3 raise", 1);
        key_ev(3, 0); tick();
        chk("R2 key clear", key_state, 0);
        chk_irq("R5 mode0 set keeps", 1);
        data_rd = 1; tick();
        chk_irq("R6 read releases", 0);
    endtask

    task automatic t_mask();
        mask_we = 1; mask_wdata = 16'h00F0; tick();
        key_ev(5, 1); tick();
        chk("R4 key state", key_state, 16'h0020);
        chk_irq("R4 masked no raise", 0);
        key_ev(9, 1); tick();
        chk_irq("R3 unmasked raise", 1);
        key_ev(9, 0); tick();
        key_ev(5, 0); tick();
        chk_irq("R5 still held", 1);
        ctl_we = 1; ctl_wdata = 16'h6800; tick();
        chk_irq("R7 scan release", 0);
        chk("R8 ctl layout", ctl_rdata, 16'h6800);
    endtask

    task automatic t_release_mode();
        cfg_we = 1; cfg_wdata = 16'h0000; tick();
        chk("R9 mode0 readback", cfg_rdata, 16'h0000);
        ctl_we = 1; ctl_wdata = 16'h1000; tick();
        chk("R8 idle flag", ctl_rdata, 16'h5000);
        key_ev(0, 1); tick();
        chk_irq("R3 raise mode0", 1);
        chk("R8 active layout", ctl_rdata, 16'h9000);
        data_rd = 1; tick();
        chk_irq("R6 read ignored", 1);
        ctl_we = 1; ctl_wdata = 16'h1000; tick();
        chk_irq("R7 no scan keeps", 1);
        key_ev(4, 1); tick();
        chk_irq("R5 masked press keeps", 1);
        key_ev(0, 0); tick();
        chk("R2 masked held", key_state, 16'h0010);
        chk_irq("R5 release rule", 0);
        key_ev(4, 0); tick();
        chk("R2 all clear", key_state, 0);
    endtask

    task automatic t_same_cycle();
        cfg_we = 1; cfg_wdata = 16'h4000; tick();
        chk("R9 mode1 readback", cfg_rdata, 16'h4000);
        key_ev(1, 1); ctl_we = 1; ctl_wdata = 16'h4000; tick();
        chk("R10 key applied", key_state, 16'h0002);
        chk_irq("R10 scan wins", 0);
        key_ev(1, 0); tick();
        cfg_we = 1; cfg_wdata = 16'h8000; tick();
        chk("R9 mode2 readback", cfg_rdata, 16'h0000);
        key_ev(2, 1); data_rd = 1; tick();
        chk("R10 key applied rd", key_state, 16'h0004);
        chk_irq("R10 read wins", 0);
        key_ev(2, 0); tick();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        tick();
        t_reset();
        t_default_mode();
        t_mask();
        t_release_mode();
        t_same_cycle();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule